// File: doc/BRIEF.md
# Access-List Address Space Resolver

This block turns a 32-bit access-list token, taken from one of the access registers, into the 64-bit control element of an address space. Two tokens, and register zero, resolve at once to the primary or secondary control element. Any other token starts a chain of dependent memory reads. The chain reads a list descriptor, a list entry and a second-table entry, and in some cases one byte of an authority table. The block validates each result as it arrives, and the first failed check ends the resolution with an exception code.

The caller raises `start` with the register number, the token, the access mode and the current control values. The block then holds `busy` and drives a single read port, which returns 64 bits per request. When it finishes, it pulses `done` for one cycle. The control element or the exception code stays on the outputs until the next request.

Top module: `aspace_resolver`

## Requirements
- R1: A request with register number 0, or with token 0, completes with `done` one cycle after `start`, `exc_code`=0 and `asce_out`=`cr_primary`. A request with token 1 does the same with `cr_secondary`. Neither issues a memory read.
- R2: A register number of 16 or more completes with `done` one cycle after `start` and `bad_reg`=1, and issues no memory read.
- R3: The token is laid out from bit 31 down as follows: seven reserved bits [31:25], the private bit [24], the 8-bit sequence number [23:16] and the 16-bit entry number [15:0]. A nonzero reserved field completes with code 1 and no read.
- R4: The private bit selects `cr_desc_priv` (set) or `cr_desc_pub` (clear) as the descriptor base. The base is ANDed with 0x7FFFFFC0, and the 32-bit descriptor is read at base+16. The descriptor holds bit 31 unused, the list origin in [30:7] and the list length in [6:0]. If entry number / 8 exceeds the length, the result is code 2.
- R5: The list entry sits at origin*128 + entry*16. If that sum exceeds 0x7FFFFFFF, the result is code 3 and no entry is read.
- R6: The list entry is 16 bytes. Its first word holds invalid [63], fetch-only [57], private [56], sequence number [55:48] and authorization index [47:32]. Its second word holds the second-table origin [62:38] and a 32-bit sequence number [31:0]. An invalid entry gives code 2. A sequence number that differs from the token's gives code 4.
- R7: The second-table entry is read at origin*64. Its first word holds invalid [63], authority origin [62:34] and authority length [15:4]. The word at +16 holds its sequence number in [31:0], and the word at +8 holds the control element. An invalid entry gives code 5. A sequence number that differs from the list entry's gives code 6.
- R8: The authority check applies only to a private list entry whose index differs from `cr_eax`. In that case, eax/16 greater than the authority length gives code 7. Otherwise the byte at auth_origin*4 + eax/4 is read. The bit selected by mask 0x40 >> ((eax&3)*2) must be 1, or the result is code 7.
- R9: A fetch-only list entry used with `is_store`=1 gives code 8. With `is_store`=0 the same entry resolves normally.
- R10: A resolution that passes every check gives code 0 and returns the control element from second-table entry +8. A walk without the authority check makes exactly six reads.
- R11: `busy` is high from the cycle after a walk's `start` until `done`, and `done` is a one-cycle pulse. A `start` while busy is ignored. `mem_req` holds with a stable `mem_addr` until `mem_ack`. The returned word puts the byte at the address in bits [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| ar_num | input | 5 | Access register number |
| token | input | 32 | Access-list token |
| is_store | input | 1 | 1 for a store access, 0 for a fetch |
| cr_primary | input | 64 | Primary control element |
| cr_secondary | input | 64 | Secondary control element |
| cr_desc_pub | input | 32 | Descriptor base for non-private tokens |
| cr_desc_priv | input | 32 | Descriptor base for private tokens |
| cr_eax | input | 16 | Extended authorization index |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_reg | output | 1 | Register number out of range |
| exc_code | output | 4 | Exception code, 0 for none |
| asce_out | output | 64 | Resolved control element |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, byte at address in [63:56] |

## Verification
The hardest path to reach is the authority bitmap probe. It needs a private list entry, a sequence match at both table levels and an index that differs from the entry's own. The bench sets up one consistent descriptor, list and second-table chain in a sparse byte memory. It then sweeps the authority index over 0..63 against a computed bitmap, which crosses the length limit and all four bit lanes in each byte. The entry-number sweep and the top-of-space descriptor reach the length and addressing boundaries from the same memory image.

// File: rtl/alr_pkg.sv
package alr_pkg;
  localparam int TOK_W  = 32;
  localparam int CE_W   = 64;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] DESC_MASK = 32'h7FFF_FFC0;
  localparam logic [ADDR_W-1:0] DESC_OFS  = 32'd16;
  localparam logic [ADDR_W:0]   TOP_LIMIT = 33'h0_7FFF_FFFF;

  typedef enum logic [3:0] {
    EXC_NONE   = 4'd0,
    EXC_TOKEN  = 4'd1,
    EXC_ENTRY  = 4'd2,
    EXC_ADDR   = 4'd3,
    EXC_ENTSEQ = 4'd4,
    EXC_SVALID = 4'd5,
    EXC_SSEQ   = 4'd6,
    EXC_AUTH   = 4'd7,
    EXC_PROT   = 4'd8
  } exc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_ALE0, S_ALE1, S_ASTE0, S_ASTESN, S_AUTH, S_ASCE
  } st_t;
endpackage

// File: rtl/alr_token_chk.sv
module alr_token_chk
  import alr_pkg::*;
#(
  parameter int NREG = 16,
  localparam int ARW = $clog2(NREG) + 1
) (
  input  logic [ARW-1:0]    ar_num,
  input  logic [TOK_W-1:0]  token,
  input  logic [ADDR_W-1:0] cr_desc_pub,
  input  logic [ADDR_W-1:0] cr_desc_priv,
  output logic              reg_bad,
  output logic              use_pri,
  output logic              use_sec,
  output logic              rsv_bad,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    reg_bad   = (ar_num >= ARW'(NREG));
    use_pri   = (ar_num == '0) || (token == '0);
    use_sec   = (token == TOK_W'(1));
    rsv_bad   = (token[31:25] != 7'd0);
    base      = token[24] ? cr_desc_priv : cr_desc_pub;
    desc_addr = (base & DESC_MASK) + DESC_OFS;
  end
endmodule

// File: rtl/alr_auth_probe.sv
module alr_auth_probe
  import alr_pkg::*;
(
  input  logic              ale_priv,
  input  logic [15:0]       ale_ax,
  input  logic [15:0]       eax,
  input  logic [11:0]       atl,
  input  logic [28:0]       ato,
  input  logic [7:0]        probe_byte,
  output logic              need,
  output logic              len_fail,
  output logic [ADDR_W-1:0] probe_addr,
  output logic              bit_ok
);
  logic [3:0] lane;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = probe_byte[6-2*g];
  end

  always_comb begin
    need       = ale_priv && (ale_ax != eax);
    len_fail   = (eax[15:4] > atl);
    probe_addr = {1'b0, ato, 2'b00} + {18'd0, eax[15:2]};
    bit_ok     = lane[eax[1:0]];
  end
endmodule

// File: rtl/aspace_resolver.sv
module aspace_resolver
  import alr_pkg::*;
#(
  parameter int NREG = 16,
  localparam int ARW = $clog2(NREG) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ARW-1:0]    ar_num,
  input  logic [TOK_W-1:0]  token,
  input  logic              is_store,
  input  logic [CE_W-1:0]   cr_primary,
  input  logic [CE_W-1:0]   cr_secondary,
  input  logic [ADDR_W-1:0] cr_desc_pub,
  input  logic [ADDR_W-1:0] cr_desc_priv,
  input  logic [15:0]       cr_eax,
  output logic              busy,
  output logic              done,
  output logic              bad_reg,
  output logic [3:0]        exc_code,
  output logic [CE_W-1:0]   asce_out,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  st_t  state, nxt;
  exc_t fail;

  logic              reg_bad, use_pri, use_sec, rsv_bad;
  logic [ADDR_W-1:0] desc_addr, naddr, probe_addr, aste_base;
  logic              auth_need, auth_len_fail, auth_bit_ok;
  logic [15:0]       tok_alen, eax_q, ale_ax;
  logic [7:0]        tok_sn;
  logic              st_q, ale_fo, ale_priv;
  logic [31:0]       ale_sn;
  logic [28:0]       ato_q;
  logic [11:0]       atl_q;
  logic [ADDR_W:0]   ent_sum;

  alr_token_chk #(.NREG(NREG)) u_tok (
    .ar_num(ar_num), .token(token), .cr_desc_pub(cr_desc_pub),
    .cr_desc_priv(cr_desc_priv), .reg_bad(reg_bad), .use_pri(use_pri),
    .use_sec(use_sec), .rsv_bad(rsv_bad), .desc_addr(desc_addr)
  );

  alr_auth_probe u_auth (
    .ale_priv(ale_priv), .ale_ax(ale_ax), .eax(eax_q), .atl(atl_q),
    .ato(ato_q), .probe_byte(mem_rdata[63:56]), .need(auth_need),
    .len_fail(auth_len_fail), .probe_addr(probe_addr), .bit_ok(auth_bit_ok)
  );

  // Check and next-read decision for the word returned in the current state
  always_comb begin
    fail    = EXC_NONE;
    nxt     = S_IDLE;
    naddr   = mem_addr;
    ent_sum = {2'b00, mem_rdata[62:39], 7'd0} + {13'd0, tok_alen, 4'd0};
    case (state)
      S_DESC: begin
        if (tok_alen[15:3] > {6'd0, mem_rdata[38:32]}) fail = EXC_ENTRY;
        else if (ent_sum > TOP_LIMIT)                   fail = EXC_ADDR;
        else begin nxt = S_ALE0; naddr = ent_sum[ADDR_W-1:0]; end
      end
      S_ALE0: begin
        if (mem_rdata[63])                      fail = EXC_ENTRY;
        else if (mem_rdata[55:48] != tok_sn)    fail = EXC_ENTSEQ;
        else begin nxt = S_ALE1; naddr = mem_addr + 32'd8; end
      end
      S_ALE1: begin
        nxt   = S_ASTE0;
        naddr = {1'b0, mem_rdata[62:38], 6'd0};
      end
      S_ASTE0: begin
        if (mem_rdata[63]) fail = EXC_SVALID;
        else begin nxt = S_ASTESN; naddr = aste_base + 32'd16; end
      end
      S_ASTESN: begin
        if (mem_rdata[31:0] != ale_sn) fail = EXC_SSEQ;
        else if (auth_need) begin
          if (auth_len_fail) fail = EXC_AUTH;
          else begin nxt = S_AUTH; naddr = probe_addr; end
        end
        else if (ale_fo && st_q) fail = EXC_PROT;
        else begin nxt = S_ASCE; naddr = aste_base + 32'd8; end
      end
      S_AUTH: begin
        if (!auth_bit_ok)        fail = EXC_AUTH;
        else if (ale_fo && st_q) fail = EXC_PROT;
        else begin nxt = S_ASCE; naddr = aste_base + 32'd8; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; busy <= 1'b0; done <= 1'b0; bad_reg <= 1'b0;
      exc_code <= EXC_NONE; asce_out <= '0; mem_req <= 1'b0; mem_addr <= '0;
      tok_alen <= '0; tok_sn <= '0; eax_q <= '0; st_q <= 1'b0;
      ale_fo <= 1'b0; ale_priv <= 1'b0; ale_ax <= '0; ale_sn <= '0;
      aste_base <= '0; ato_q <= '0; atl_q <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          bad_reg  <= 1'b0;
          exc_code <= EXC_NONE;
          if (reg_bad) begin
            bad_reg <= 1'b1; done <= 1'b1;
          end else if (use_pri) begin
            asce_out <= cr_primary; done <= 1'b1;
          end else if (use_sec) begin
            asce_out <= cr_secondary; done <= 1'b1;
          end else if (rsv_bad) begin
            exc_code <= EXC_TOKEN; done <= 1'b1;
          end else begin
            busy     <= 1'b1;
            state    <= S_DESC;
            mem_req  <= 1'b1;
            mem_addr <= desc_addr;
            tok_alen <= token[15:0];
            tok_sn   <= token[23:16];
            eax_q    <= cr_eax;
            st_q     <= is_store;
          end
        end
      end else if (mem_ack) begin
        mem_req <= 1'b0;
        case (state)
          S_ALE0: begin
            ale_fo <= mem_rdata[57]; ale_priv <= mem_rdata[56];
            ale_ax <= mem_rdata[47:32];
          end
          S_ALE1: begin
            ale_sn <= mem_rdata[31:0]; aste_base <= naddr;
          end
          S_ASTE0: begin
            ato_q <= mem_rdata[62:34]; atl_q <= mem_rdata[15:4];
          end
          default: ;
        endcase
        if (fail != EXC_NONE) begin
          exc_code <= fail; done <= 1'b1; busy <= 1'b0; state <= S_IDLE;
        end else if (nxt == S_IDLE) begin
          asce_out <= mem_rdata; done <= 1'b1; busy <= 1'b0; state <= S_IDLE;
        end else begin
          state <= nxt; mem_req <= 1'b1; mem_addr <= naddr;
        end
      end
    end
  end

  // R1: shortcut tokens answer on the next cycle from the primary element
  p_shortcut_pri_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (ar_num < ARW'(NREG)) && ((ar_num == '0) || (token == '0)))
    |=> (done && exc_code == 4'd0 && asce_out == $past(cr_primary)));

  // R2: out-of-range register flagged on the next cycle
  p_bad_reg_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (ar_num >= ARW'(NREG))) |=> (done && bad_reg && !mem_req));

  // R3: reserved bits give code 1 without a walk
  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (ar_num != '0) && (ar_num < ARW'(NREG)) &&
     (token > 32'd1) && (token[31:25] != 7'd0))
    |=> (done && exc_code == 4'd1 && !busy));

  // R11: request held with stable address until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11: done is a single-cycle pulse and never overlaps busy
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !(done && busy)));
endmodule

// File: tb/sim_aspace_resolver.sv
module sim_aspace_resolver;
  localparam int CLK_P = 10;
  localparam int LAT   = 2;

  logic clk = 0, rst = 1, start = 0, is_store = 0, mem_ack = 0;
  logic [4:0]  ar_num = 0;
  logic [31:0] token = 0, cr_desc_pub = 0, cr_desc_priv = 0, mem_addr;
  logic [63:0] cr_primary = 0, cr_secondary = 0, mem_rdata = 0, asce_out;
  logic [15:0] cr_eax = 0;
  logic busy, done, bad_reg, mem_req;
  logic [3:0] exc_code;

  aspace_resolver u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [7:0] mem [logic [31:0]];
  int reads = 0, lat = 0;
  int checks = 0, failures = 0;

  function automatic logic [7:0] rb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [63:0] rd64(input logic [31:0] a);
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[55:0], rb(a + i)};
    return v;
  endfunction
  task automatic put64(input logic [31:0] a, input logic [63:0] v);
    for (int i = 0; i < 8; i++) mem[a + i] = v[63-8*i -: 8];
  endtask
  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[31-8*i -: 8];
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin mem_ack = 0; lat = 0; end
    else if (!rst && mem_req) begin
      if (lat == LAT) begin
        mem_ack = 1; mem_rdata = rd64(mem_addr); reads++; lat = 0;
      end else lat++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tk(input bit p, input logic [7:0] sn, input logic [15:0] n);
    return {7'd0, p, sn, n};
  endfunction
  function automatic logic [63:0] ale0(input bit i, input bit fo, input bit p, input logic [7:0] sn, input logic [15:0] ax);
    return {i, 5'd0, fo, p, sn, ax, 32'd0};
  endfunction
  function automatic logic [63:0] ale1(input logic [24:0] so, input logic [31:0] sn);
    return {1'b0, so, 6'd0, sn};
  endfunction
  function automatic logic [7:0] pat(input int k);
    return 8'(k * 29) ^ 8'h96;
  endfunction

  logic [3:0]  r_exc;
  logic [63:0] r_ce;
  logic        r_bad;
  int          r_reads;
  bit          saw_busy;

  task automatic run(input logic [4:0] ar, input logic [31:0] tok, input bit st);
    int n0 = reads, cyc = 0;
    @(negedge clk);
    ar_num = ar; token = tok; is_store = st; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    saw_busy = busy;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (cyc >= 2000) chk(0, "R11 timeout", 0, 1);
    r_exc = exc_code; r_ce = asce_out; r_bad = bad_reg; r_reads = reads - n0;
  endtask

  localparam logic [63:0] CE_A = 64'h1122_3344_5566_7788;
  localparam logic [63:0] CE_B = 64'hA5A5_0F0F_3C3C_9696;
  localparam logic [7:0]  SN   = 8'h3C;

  initial begin
    #(CLK_P * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cr_primary = 64'hFEED_0000_0000_0001; cr_secondary = 64'hBEEF_0000_0000_0002;
    cr_desc_pub = 32'h0001_003F; cr_desc_priv = 32'h8002_0000;
    put32(32'h0001_0010, {1'b0, 24'h1000, 7'd3});
    for (int n = 0; n < 32; n++) begin
      put64(32'h80000 + n*16, ale0(0, 0, 0, SN, 16'h0));
      put64(32'h80008 + n*16, ale1(25'h8000, 32'hCAFE_0001));
    end
    put64(32'h80050, ale0(1, 0, 0, SN, 0));
    put64(32'h80068, ale1(25'hD000, 32'hCAFE_0001));
    put64(32'h80078, ale1(25'h8000, 32'h1234_5678));
    put64(32'h80080, ale0(0, 0, 1, SN, 16'hFFFF));
    put64(32'h80090, ale0(0, 0, 1, SN, 16'h0005));
    put64(32'h800A0, ale0(0, 1, 0, SN, 0));
    put64(32'h200000, {1'b0, 29'h100000, 2'b0, 16'h0, 12'd2, 4'd0});
    put64(32'h200008, CE_A);
    put64(32'h200010, {32'd0, 32'hCAFE_0001});
    put32(32'h0002_0010, {1'b0, 24'h2000, 7'd0});
    put64(32'h100000, ale0(0, 0, 0, SN, 0));
    put64(32'h100008, ale1(25'hC000, 32'h0000_BEEF));
    put64(32'h300000, 64'd0);
    put64(32'h300008, CE_B);
    put64(32'h300010, {32'd0, 32'h0000_BEEF});
    put64(32'h340000, {1'b1, 63'd0});
    for (int k = 0; k < 16; k++) mem[32'h400000 + k] = pat(k);
    put32(32'h0003_0010, {1'b0, 24'hFFFFFF, 7'd3});

    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0 && mem_req == 0 && exc_code == 0, "R11 reset", {busy, done, mem_req}, 0);
    rst = 0;

    // R1 shortcuts
    run(0, tk(0, SN, 5), 0);
    chk(r_ce == cr_primary && r_exc == 0 && r_reads == 0, "R1 reg0", r_ce, cr_primary);
    run(3, 0, 0);
    chk(r_ce == cr_primary && r_reads == 0, "R1 token0", r_ce, cr_primary);
    run(3, 1, 1);
    chk(r_ce == cr_secondary && r_exc == 0 && r_reads == 0, "R1 token1", r_ce, cr_secondary);
    // R2 register range sweep
    for (int a = 16; a < 32; a++) begin
      run(5'(a), tk(0, SN, 1), 0);
      chk(r_bad == 1 && r_reads == 0, "R2 bad reg", r_bad, 1);
    end
    run(15, tk(0, SN, 1), 0);
    chk(r_bad == 0 && r_exc == 0 && r_ce == CE_A, "R2 reg15 ok", r_ce, CE_A);
    // R3 reserved bits
    for (int b = 25; b < 32; b++) begin
      run(2, tk(0, SN, 1) | (32'd1 << b), 0);
      chk(r_exc == 1 && r_reads == 0, "R3 reserved", r_exc, 1);
    end
    // R4 R10 entry-number sweep against length 3
    for (int n = 0; n < 40; n++) begin
      run(2, tk(0, SN, 16'(n)), 0);
      if (n == 5)
        chk(r_exc == 2, "R6 invalid entry", r_exc, 2);
      else if (n == 6)
        chk(r_exc == 5, "R7 invalid second entry", r_exc, 5);
      else if (n == 7)
        chk(r_exc == 6, "R7 second sequence", r_exc, 6);
      else if (n == 8 || n == 9 || n == 10)
        ;
      else if (n >= 32)
        chk(r_exc == 2 && r_reads == 1, "R4 length", r_exc, 2);
      else
        chk(r_exc == 0 && r_ce == CE_A && r_reads == 6, "R10 resolve", r_ce, CE_A);
    end
    // R4 private descriptor base
    run(4, tk(1, SN, 0), 0);
    chk(r_exc == 0 && r_ce == CE_B, "R4 private base", r_ce, CE_B);
    run(4, tk(1, SN, 8), 0);
    chk(r_exc == 2, "R4 private length 0", r_exc, 2);
    // R6 sequence mismatch
    run(2, tk(0, 8'h3D, 2), 0);
    chk(r_exc == 4, "R6 entry sequence", r_exc, 4);
    // R9 fetch-only
    run(2, tk(0, SN, 10), 1);
    chk(r_exc == 8, "R9 store fetch-only", r_exc, 8);
    run(2, tk(0, SN, 10), 0);
    chk(r_exc == 0 && r_ce == CE_A, "R9 fetch fetch-only", r_ce, CE_A);
    run(2, tk(0, SN, 2), 1);
    chk(r_exc == 0, "R9 store normal", r_exc, 0);
    // R8 authority sweep
    for (int e = 0; e < 64; e++) begin
      bit ok;
      logic [3:0] ex;
      cr_eax = 16'(e);
      ok = ((e >> 4) <= 2) && pat(e >> 2)[6 - 2*(e & 3)];
      ex = ok ? 4'd0 : 4'd7;
      run(2, tk(0, SN, 8), 0);
      chk(r_exc == ex, "R8 authority sweep", r_exc, ex);
      if ((e >> 4) > 2) chk(r_reads == 5, "R8 length no probe", r_reads, 5);
    end
    mem[32'h400001] = 8'h00;
    cr_eax = 16'd5;
    run(2, tk(0, SN, 8), 0);
    chk(r_exc == 7, "R8 zero bit", r_exc, 7);
    run(2, tk(0, SN, 9), 0);
    chk(r_exc == 0 && r_reads == 6, "R8 equal index skips", r_reads, 6);
    cr_eax = 16'd0;
    // R5 top of space
    cr_desc_pub = 32'h0003_0000;
    run(2, tk(0, 8'h00, 8), 0);
    chk(r_exc == 3 && r_reads == 1, "R5 overflow", r_exc, 3);
    run(2, tk(0, 8'h00, 7), 0);
    chk(r_exc == 0 && r_ce == 0, "R5 last fits", r_exc, 0);
    cr_desc_pub = 32'h0001_003F;
    // R11 start while busy ignored
    fork
      run(2, tk(0, SN, 3), 0);
      begin
        repeat (3) @(negedge clk);
        ar_num = 5'd20; start = 1;
        @(negedge clk);
        start = 0;
      end
    join
    chk(saw_busy && r_bad == 0 && r_exc == 0 && r_ce == CE_A, "R11 busy ignores start", r_ce, CE_A);
    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0, "R11 stays idle", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule